// File: doc/BRIEF.md
# Coefficient-Varying Switch Transient Model

This block is the per-cell core of a real-time power converter simulator. It models one commutation cell: an upper and a lower transistor, each with an antiparallel diode. On every simulation step it samples the gate command and the sign of the load current and decides which transistor conducts. For each of four per-unit transfer functions (current and voltage of each transistor) it then picks the coefficient set that matches that transistor's conduction state.

Each transfer function is a parallel sum of a first-order section and a second-order section. Its input is a unit step that follows the conduction state. The per-unit results are scaled by the DC-link voltage or by the load current magnitude, and the diode quantities are derived from them. Coefficients are preloaded through a small write port while no step is in flight. A full update takes three clock cycles, well inside a 50 ns step at 200 MHz. All values are signed Q6.18 (25 bits in total, 18 fractional).

Top module: `cv_switch_cell`

## Requirements
- R1: On the clock edge that accepts `step_strobe`, the cell captures `gate_cmd` and the sign of `load_i`. The upper transistor conducts when `gate_cmd`=1 and `load_i`>=0. The lower transistor conducts when `gate_cmd`=0 and `load_i`<0. `t_state[0]` reports the upper transistor and `t_state[1]` the lower one.
- R2: The edge that accepts a strobe starts the update. `done` is a one-cycle pulse that goes high after the third rising edge from that edge. The eight outputs change only in the cycle `done` is high and hold otherwise. A strobe that arrives while an update is in flight (the two edges after acceptance) is ignored.
- R3: Coefficient memory address is {tf[1:0], on, k[2:0]}. tf selects the function: 0 = upper current, 1 = upper voltage, 2 = lower current, 3 = lower voltage. `on`=1 selects the conducting set. k selects the coefficient: 0=p, 1=g1, 2=a1, 3=a2, 4=g2.
- R4: The input u of a current function is 1.0 while its transistor conducts and 0 otherwise. The input u of a voltage function is 1.0 while its transistor is off and 0 otherwise.
- R5: Each update applies three assignments, all using old state values: s1 <= p*s1 + g1*u; s2 <= a1*s2 + a2*s2d + g2*u; s2d <= s2. The function output is then y = s1 + s2. Every product is floored to 18 fractional bits (arithmetic right shift by 18).
- R6: When a transistor changes state, the coefficients of its two functions switch to the other set on the same update. The section states carry over unchanged.
- R7: `t1_v`=y1*vdc, `t2_v`=y3*vdc, `t1_i`=y0*|load_i|, `t2_i`=y2*|load_i|, using the same product rule as R5.
- R8: `d1_v`=-`t1_v` and `d2_v`=-`t2_v`. When `load_i`>=0, `d2_i`=max(|load_i|-`t1_i`,0) and `d1_i`=0. When `load_i`<0, `d1_i`=max(|load_i|-`t2_i`,0) and `d2_i`=0.
- R9: A coefficient write is accepted only while no update is in flight. A write issued during an update is dropped.
- R10: Reset clears all outputs, `done`, the captured state, every section state and every coefficient word to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_strobe | input | 1 | Starts one simulation step |
| gate_cmd | input | 1 | Gate command, 1 = upper transistor driven |
| load_i | input | W | Load current, Q6.18 signed |
| vdc | input | W | DC-link voltage, Q6.18 signed |
| cw_en | input | 1 | Coefficient write enable |
| cw_addr | input | 6 | Coefficient address {tf, on, k} |
| cw_data | input | W | Coefficient value |
| done | output | 1 | New outputs valid |
| t_state | output | 2 | Conduction state {lower, upper} |
| t1_i | output | W | Upper transistor current |
| t1_v | output | W | Upper transistor voltage |
| t2_i | output | W | Lower transistor current |
| t2_v | output | W | Lower transistor voltage |
| d1_i | output | W | Upper diode current |
| d1_v | output | W | Upper diode voltage |
| d2_i | output | W | Lower diode current |
| d2_v | output | W | Lower diode voltage |

## Verification
A run of steps with the upper transistor conducting and positive current shows the first- and second-order sections settling. It also tells the current functions apart from the voltage functions through their opposite step inputs. Flipping to the lower transistor with negative current, and then to gate high with negative current, exercises the coefficient swap with state carried over and both diode branches. That last pattern leaves neither transistor conducting. A strobe held into a busy cycle, a write issued mid-update and a reset during operation each separate a correct cell from one that restarts, accepts the write or keeps stale state.

// File: rtl/cv_switch_cell.sv
module cv_switch_cell #(
  parameter int W = 25,
  parameter int F = 18
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step_strobe,
  input  logic                gate_cmd,
  input  logic signed [W-1:0] load_i,
  input  logic signed [W-1:0] vdc,
  input  logic                cw_en,
  input  logic [5:0]          cw_addr,
  input  logic signed [W-1:0] cw_data,
  output logic                done,
  output logic [1:0]          t_state,
  output logic signed [W-1:0] t1_i,
  output logic signed [W-1:0] t1_v,
  output logic signed [W-1:0] t2_i,
  output logic signed [W-1:0] t2_v,
  output logic signed [W-1:0] d1_i,
  output logic signed [W-1:0] d1_v,
  output logic signed [W-1:0] d2_i,
  output logic signed [W-1:0] d2_v
);
  localparam int DEPTH = 64;
  localparam logic signed [W-1:0] ONE = {{(W-F-1){1'b0}}, 1'b1, {F{1'b0}}};

  function automatic logic signed [W-1:0] qmul(input logic signed [W-1:0] a,
                                               input logic signed [W-1:0] b);
    logic signed [2*W-1:0] p;
    p = (2*W)'(a) * (2*W)'(b);
    return W'(p >>> F);
  endfunction

  logic ph1, ph2, accept, busy;
  logic gate_q, neg_q, up_on, lo_on;
  logic signed [W-1:0] vdc_q, mag_q;
  logic signed [W-1:0] mem [DEPTH];
  logic signed [W-1:0] y [4];

  assign busy    = ph1 | ph2;
  assign accept  = step_strobe & ~busy;
  assign up_on   = gate_q & ~neg_q;
  assign lo_on   = ~gate_q & neg_q;
  assign t_state = {lo_on, up_on};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph1 <= 1'b0; ph2 <= 1'b0; done <= 1'b0;
      gate_q <= 1'b0; neg_q <= 1'b0; vdc_q <= '0; mag_q <= '0;
    end else begin
      ph1  <= accept;
      ph2  <= ph1;
      done <= ph2;
      if (accept) begin
        gate_q <= gate_cmd;
        neg_q  <= load_i[W-1];
        vdc_q  <= vdc;
        mag_q  <= load_i[W-1] ? -load_i : load_i;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (cw_en && !busy) begin
      mem[cw_addr] <= cw_data;
    end
  end

  for (genvar t = 0; t < 4; t++) begin : g_tf
    localparam logic [1:0] TID = 2'(t);
    localparam bit IS_V = (t % 2) == 1;
    logic st;
    logic signed [W-1:0] u, s1, s2, s2d;
    logic signed [W-1:0] cp, cg1, ca1, ca2, cg2;

    assign st  = (t < 2) ? up_on : lo_on;
    assign u   = (st != IS_V) ? ONE : '0;
    assign cp  = mem[{TID, st, 3'd0}];
    assign cg1 = mem[{TID, st, 3'd1}];
    assign ca1 = mem[{TID, st, 3'd2}];
    assign ca2 = mem[{TID, st, 3'd3}];
    assign cg2 = mem[{TID, st, 3'd4}];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        s1 <= '0; s2 <= '0; s2d <= '0;
      end else if (ph1) begin
        s1  <= qmul(cp, s1) + qmul(cg1, u);
        s2  <= qmul(ca1, s2) + qmul(ca2, s2d) + qmul(cg2, u);
        s2d <= s2;
      end
    end

    assign y[t] = s1 + s2;
  end

  logic signed [W-1:0] i1n, v1n, i2n, v2n, rem_up, rem_lo;
  assign i1n    = qmul(y[0], mag_q);
  assign v1n    = qmul(y[1], vdc_q);
  assign i2n    = qmul(y[2], mag_q);
  assign v2n    = qmul(y[3], vdc_q);
  assign rem_up = mag_q - i1n;
  assign rem_lo = mag_q - i2n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t1_i <= '0; t1_v <= '0; t2_i <= '0; t2_v <= '0;
      d1_i <= '0; d1_v <= '0; d2_i <= '0; d2_v <= '0;
    end else if (ph2) begin
      t1_i <= i1n;
      t1_v <= v1n;
      t2_i <= i2n;
      t2_v <= v2n;
      d1_v <= -v1n;
      d2_v <= -v2n;
      d2_i <= (!neg_q && !rem_up[W-1]) ? rem_up : '0;
      d1_i <= (neg_q && !rem_lo[W-1]) ? rem_lo : '0;
    end
  end
endmodule

// File: rtl/cv_switch_cell_chk.sv
module cv_switch_cell_chk #(
  parameter int W = 25
) (
  input logic                clk,
  input logic                rst_n,
  input logic                step_strobe,
  input logic                gate_cmd,
  input logic                load_neg,
  input logic                done,
  input logic [1:0]          t_state,
  input logic signed [W-1:0] t1_i,
  input logic signed [W-1:0] t1_v,
  input logic signed [W-1:0] t2_i,
  input logic signed [W-1:0] t2_v,
  input logic signed [W-1:0] d1_i,
  input logic signed [W-1:0] d2_i
);
  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(step_strobe, 3)); // R2

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R2

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(t1_i) && $stable(t1_v) && $stable(t2_i) && $stable(t2_v)
               && $stable(d1_i) && $stable(d2_i))); // R2

  AST_STATE_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (t_state == {!$past(gate_cmd, 3) && $past(load_neg, 3),
                          $past(gate_cmd, 3) && !$past(load_neg, 3)})); // R1

  AST_ONE_DIODE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (d1_i == '0 || d2_i == '0)); // R8
endmodule

bind cv_switch_cell cv_switch_cell_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .step_strobe(step_strobe), .gate_cmd(gate_cmd),
  .load_neg(load_i[W-1]), .done(done), .t_state(t_state),
  .t1_i(t1_i), .t1_v(t1_v), .t2_i(t2_i), .t2_v(t2_v),
  .d1_i(d1_i), .d2_i(d2_i)
);

// File: tb/cv_switch_cell_tb.sv
module cv_switch_cell_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 25;
  localparam longint ONE = 262144;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step_strobe = 1'b0;
  logic gate_cmd = 1'b0;
  logic signed [W-1:0] load_i = '0;
  logic signed [W-1:0] vdc = '0;
  logic cw_en = 1'b0;
  logic [5:0] cw_addr = '0;
  logic signed [W-1:0] cw_data = '0;
  logic done;
  logic [1:0] t_state;
  logic signed [W-1:0] t1_i, t1_v, t2_i, t2_v, d1_i, d1_v, d2_i, d2_v;

  int n_chk = 0;
  int n_bad = 0;

  longint m_mem [64];
  longint rs1 [4];
  longint rs2 [4];
  longint rs2d [4];
  longint e_out [8];
  int e_state;

  always #(CLK_PERIOD/2) clk = ~clk;

  cv_switch_cell dut_i (
    .clk(clk), .rst_n(rst_n), .step_strobe(step_strobe), .gate_cmd(gate_cmd),
    .load_i(load_i), .vdc(vdc), .cw_en(cw_en), .cw_addr(cw_addr), .cw_data(cw_data),
    .done(done), .t_state(t_state),
    .t1_i(t1_i), .t1_v(t1_v), .t2_i(t2_i), .t2_v(t2_v),
    .d1_i(d1_i), .d1_v(d1_v), .d2_i(d2_i), .d2_v(d2_v)
  );

  function automatic longint wrap(input longint v);
    logic signed [W-1:0] w;
    w = v[W-1:0];
    return longint'(w);
  endfunction

  function automatic longint qm(input longint a, input longint b);
    return wrap((a * b) >>> 18);
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 64; i++) m_mem[i] = 0;
    for (int t = 0; t < 4; t++) begin rs1[t] = 0; rs2[t] = 0; rs2d[t] = 0; end
  endtask

  task automatic model_step(input bit g, input longint il, input longint vd);
    bit up, lo, st, isv;
    longint u, mag, n1, n2, yv[4], rem;
    int base;
    up = g && (il >= 0);
    lo = !g && (il < 0);
    e_state = {30'd0, lo, up};
    mag = (il < 0) ? -il : il;
    for (int t = 0; t < 4; t++) begin
      st = (t < 2) ? up : lo;
      isv = (t % 2) == 1;
      u = (st != isv) ? ONE : 0;
      base = t * 16 + (st ? 8 : 0);
      n1 = wrap(qm(m_mem[base], rs1[t]) + qm(m_mem[base+1], u));
      n2 = wrap(qm(m_mem[base+2], rs2[t]) + qm(m_mem[base+3], rs2d[t]) + qm(m_mem[base+4], u));
      rs2d[t] = rs2[t];
      rs1[t] = n1;
      rs2[t] = n2;
      yv[t] = wrap(n1 + n2);
    end
    e_out[0] = qm(yv[0], mag);
    e_out[1] = qm(yv[1], vd);
    e_out[2] = qm(yv[2], mag);
    e_out[3] = qm(yv[3], vd);
    e_out[5] = wrap(-e_out[1]);
    e_out[7] = wrap(-e_out[3]);
    rem = wrap(mag - e_out[0]);
    e_out[6] = (il >= 0 && rem >= 0) ? rem : 0;
    rem = wrap(mag - e_out[2]);
    e_out[4] = (il < 0 && rem >= 0) ? rem : 0;
  endtask

  task automatic check_outputs(input string req);
    chk(req, "t1_i", longint'(t1_i), e_out[0]);
    chk(req, "t1_v", longint'(t1_v), e_out[1]);
    chk(req, "t2_i", longint'(t2_i), e_out[2]);
    chk(req, "t2_v", longint'(t2_v), e_out[3]);
    chk(req, "d1_i", longint'(d1_i), e_out[4]);
    chk(req, "d1_v", longint'(d1_v), e_out[5]);
    chk(req, "d2_i", longint'(d2_i), e_out[6]);
    chk(req, "d2_v", longint'(d2_v), e_out[7]);
  endtask

  task automatic write_coef(input int addr, input longint val);
    @(negedge clk);
    cw_en = 1'b1; cw_addr = 6'(addr); cw_data = W'(val);
    @(negedge clk);
    cw_en = 1'b0;
    m_mem[addr] = val;
  endtask

  task automatic run_step(input bit g, input longint il, input longint vd, input string req,
                          input bit extra_strobe, input bit busy_write,
                          input int wr_addr, input longint wr_val);
    @(negedge clk);
    gate_cmd = g; load_i = W'(il); vdc = W'(vd); step_strobe = 1'b1;
    @(negedge clk);
    step_strobe = extra_strobe;
    gate_cmd = ~g;
    if (busy_write) begin cw_en = 1'b1; cw_addr = 6'(wr_addr); cw_data = W'(wr_val); end
    chk("R2", "done early1", longint'(done), 0);
    @(negedge clk);
    step_strobe = 1'b0; cw_en = 1'b0; gate_cmd = g;
    chk("R2", "done early2", longint'(done), 0);
    @(negedge clk);
    chk("R2", "done pulse", longint'(done), 1);
    model_step(g, il, vd);
    chk("R1", "t_state", longint'(t_state), longint'(e_state));
    check_outputs(req);
    @(negedge clk);
    chk("R2", "done drop", longint'(done), 0);
    if (extra_strobe) begin
      repeat (3) begin
        @(negedge clk);
        chk("R2", "no restart", longint'(done), 0);
      end
    end
    check_outputs("R2");
  endtask

  task automatic t_reset_state();
    chk("R10", "done", longint'(done), 0);
    chk("R10", "t_state", longint'(t_state), 0);
    for (int k = 0; k < 8; k++) e_out[k] = 0;
    check_outputs("R10");
  endtask

  task automatic t_load_coefs();
    for (int t = 0; t < 4; t++)
      for (int s = 0; s < 2; s++) begin
        write_coef(t*16 + s*8 + 0, ONE/2 + (s ? ONE/8 : 0) + t * (ONE/64));
        write_coef(t*16 + s*8 + 1, ONE/2 - (s ? ONE/16 : 0));
        write_coef(t*16 + s*8 + 2, ONE/4 + (s ? ONE/8 : 0));
        write_coef(t*16 + s*8 + 3, s ? ONE/16 : -(ONE/8));
        write_coef(t*16 + s*8 + 4, ONE/8 + t * (ONE/32));
      end
  endtask

  task automatic t_upper_on();
    for (int n = 0; n < 4; n++)
      run_step(1'b1, ONE + n * (ONE/4), 3*ONE/2, "R5", 1'b0, 1'b0, 0, 0);
    run_step(1'b1, 0, 2*ONE, "R4", 1'b0, 1'b0, 0, 0);
    run_step(1'b1, 3*ONE, ONE, "R7", 1'b0, 1'b0, 0, 0);
  endtask

  task automatic t_swap_lower();
    for (int n = 0; n < 3; n++)
      run_step(1'b0, -(ONE + n * (ONE/8)), 3*ONE/2, "R6", 1'b0, 1'b0, 0, 0);
  endtask

  task automatic t_both_off();
    run_step(1'b1, -(ONE/2), ONE, "R8", 1'b0, 1'b0, 0, 0);
    run_step(1'b0, ONE/2, ONE, "R8", 1'b0, 1'b0, 0, 0);
  endtask

  task automatic t_busy_strobe();
    run_step(1'b1, ONE, ONE, "R2", 1'b1, 1'b0, 0, 0);
  endtask

  task automatic t_busy_write();
    run_step(1'b1, ONE, ONE, "R9", 1'b0, 1'b1, 8, 3*ONE/4);
    run_step(1'b1, ONE, ONE, "R9", 1'b0, 1'b0, 0, 0);
    write_coef(8, ONE/4);
    run_step(1'b1, ONE, ONE, "R3", 1'b0, 1'b0, 0, 0);
  endtask

  task automatic t_reset_mid();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_clear();
    t_reset_state();
    run_step(1'b1, 2*ONE, ONE, "R10", 1'b0, 1'b0, 0, 0);
  endtask

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    @(negedge clk);
    t_load_coefs();
    t_upper_on();
    t_swap_lower();
    t_both_off();
    t_busy_strobe();
    t_busy_write();
    t_reset_mid();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R2 watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule